// File: doc/BRIEF.md
# Scanline Interrupt Detector with Frame Tracking

This block watches two buses on a cartridge and uses them to follow the picture
being drawn. The picture processor's read fetches are compared with each other.
When three identical fetches in a row carry an address with bit 13 set, the block
counts one rendered scanline. CPU bus cycles tell the block when rendering has
stopped. This happens when the CPU fetches the frame interrupt vector, or when the
CPU runs three cycles in a row with no picture fetch between them.

The block holds a scanline counter and an in-frame flag. The CPU writes a target
line number to a register. When the counted line reaches that target, an interrupt
becomes pending. The active-low interrupt output is driven low while that interrupt
is pending and enabled. A status register lets the CPU read the pending and in-frame
flags, and reading it acknowledges the interrupt. All state changes on one clock.
Each bus transfer is marked by a one-cycle strobe.

Top module: `scanline_irq_unit`

## Requirements
- R1: A picture read whose 14-bit address equals the two picture reads just before it, with address bit 13 = 1, counts as a scanline detection.
- R2: No detection happens in these cases: only two identical reads; a run where any single address bit differs in one fetch; a run of identical reads with bit 13 = 0.
- R3: While identical qualifying reads continue past three, every further read is another detection.
- R4: The first detection while in-frame is 0 sets in-frame and loads the line counter with 0. Each later detection increments the counter by one.
- R5: A CPU write to address 0x5203 sets the target line. A detection that leaves the counter equal to the target sets the pending flag.
- R6: A CPU read of 0x5204 returns pending in bit 7 and in-frame in bit 6, with all other bits 0, and it clears pending. Reads of any other address return 0.
- R7: A CPU write to 0x5204 copies data bit 7 into the interrupt enable. irq_n is 0 exactly when pending and enable are both 1.
- R8: A CPU read of 0xFFFA or 0xFFFB clears in-frame and the counter. CPU writes to those addresses, and a write of 0x00 to 0x2001, leave them unchanged.
- R9: The third consecutive CPU cycle with no picture read since the previous one clears in-frame and the counter. A status read in that same cycle already returns 0 in bit 6.
- R10: Picture write cycles neither reset the starved-cycle count nor take part in fetch matching.
- R11: After reset: in-frame, pending, enable, counter, target and fetch history are clear, and irq_n is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_stb | input | 1 | One-cycle marker of a CPU bus cycle |
| cpu_addr | input | 16 | CPU address |
| cpu_rnw | input | 1 | 1 = CPU read, 0 = CPU write |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data for the current CPU cycle (combinational) |
| ppu_stb | input | 1 | One-cycle marker of a picture bus cycle |
| ppu_addr | input | 14 | Picture bus address |
| ppu_rnw | input | 1 | 1 = picture read, 0 = picture write |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench sweeps run lengths of two, three and four identical fetches against every
small target value, with bit 13 both set and clear. This separates a correct
three-fetch threshold from thresholds one lower or one higher. It also separates a
counter that adds one per run from one that adds one per matching read. A second
sweep flips each of the 14 address bits in turn in the first fetch of a run, so that
a comparator that ignores any single bit shows up. Directed sequences then place
starved CPU cycles, interleaved picture writes, vector reads and look-alike writes.
These check that only the stated events end a frame, and that they take effect in
the stated cycle.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;

    localparam int PPU_AW      = 14;
    localparam int CPU_AW      = 16;
    localparam int DW          = 8;
    localparam int LINE_W      = 8;
    localparam int STARVE_CYC  = 3;
    localparam int A13_BIT     = 13;
    localparam int PEND_BIT    = 7;
    localparam int INFRM_BIT   = 6;
    localparam int EN_BIT      = 7;

    localparam logic [CPU_AW-1:0] REG_TARGET = 16'h5203;
    localparam logic [CPU_AW-1:0] REG_STATUS = 16'h5204;
    localparam logic [CPU_AW-1:0] VEC_LO     = 16'hFFFA;
    localparam logic [CPU_AW-1:0] VEC_HI     = 16'hFFFB;

    typedef enum logic [1:0] {
        RUN_EMPTY = 2'd0,
        RUN_ONE   = 2'd1,
        RUN_TWO   = 2'd2,
        RUN_MANY  = 2'd3
    } run_state_t;

    typedef struct packed {
        logic rd_status;
        logic wr_status;
        logic wr_target;
        logic rd_vector;
    } cpu_dec_t;

    function automatic cpu_dec_t decode_cpu(
        input logic              stb,
        input logic              rnw,
        input logic [CPU_AW-1:0] addr
    );
        cpu_dec_t d;
        d.rd_status = stb &  rnw & (addr == REG_STATUS);
        d.wr_status = stb & ~rnw & (addr == REG_STATUS);
        d.wr_target = stb & ~rnw & (addr == REG_TARGET);
        d.rd_vector = stb &  rnw & ((addr == VEC_LO) | (addr == VEC_HI));
        return d;
    endfunction

    function automatic run_state_t run_advance(input run_state_t s, input logic same);
        run_state_t n;
        if (!same || s == RUN_EMPTY) begin
            n = RUN_ONE;
        end else begin
            case (s)
                RUN_ONE: n = RUN_TWO;
                default: n = RUN_MANY;
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/fetch_run_detector.sv
module fetch_run_detector
    import scanirq_pkg::*;
#(
    parameter int AW = PPU_AW,
    parameter int QUAL_BIT = A13_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_stb,
    input  logic [AW-1:0] addr,
    output logic          line_hit
);

    logic [AW-1:0] last_q;
    run_state_t    run_q;
    logic          same;

    assign same     = (run_q != RUN_EMPTY) && (addr == last_q);
    assign line_hit = rd_stb && same && addr[QUAL_BIT] &&
                      (run_q == RUN_TWO || run_q == RUN_MANY);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
            run_q  <= RUN_EMPTY;
        end else if (rd_stb) begin
            last_q <= addr;
            run_q  <= run_advance(run_q, same);
        end
    end

    // R2
    two_not_enough_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && run_q == RUN_ONE) |-> !line_hit);

    // R1
    run_reaches_two_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && run_q == RUN_ONE && addr == last_q) |=> (run_q == RUN_TWO));

endmodule

// File: rtl/starve_monitor.sv
module starve_monitor #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic cpu_stb,
    input  logic ppu_rd,
    output logic starve_now
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] idle_q;

    assign starve_now = cpu_stb && !ppu_rd && (idle_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= '0;
        end else if (ppu_rd) begin
            idle_q <= '0;
        end else if (cpu_stb && idle_q != LAST) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    generate
        if (LIMIT > 1) begin : g_reset_chk
            // R9
            ppu_read_rearms_chk: assert property (@(posedge clk) disable iff (rst)
                ppu_rd |=> !starve_now);
        end
    endgenerate

endmodule

// File: rtl/frame_tracker.sv
module frame_tracker
    import scanirq_pkg::*;
#(
    parameter int CW = LINE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit,
    input  logic          end_frame,
    output logic          in_frame,
    output logic [CW-1:0] line,
    output logic          line_evt,
    output logic [CW-1:0] line_next
);

    logic          in_frame_q;
    logic [CW-1:0] line_q;

    assign line_evt  = hit && !end_frame;
    assign line_next = in_frame_q ? line_q + 1'b1 : '0;
    assign in_frame  = in_frame_q;
    assign line      = line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            line_q     <= '0;
        end else if (end_frame) begin
            in_frame_q <= 1'b0;
            line_q     <= '0;
        end else if (hit) begin
            in_frame_q <= 1'b1;
            line_q     <= line_next;
        end
    end

    // R4
    first_line_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !end_frame && !in_frame_q) |=> (in_frame_q && line_q == '0));

    // R4
    line_step_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !end_frame && in_frame_q) |=> (line_q == $past(line_q) + 1'b1));

    // R8
    frame_end_chk: assert property (@(posedge clk) disable iff (rst)
        end_frame |=> (!in_frame_q && line_q == '0));

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import scanirq_pkg::*;
#(
    parameter int CW = LINE_W,
    parameter int W  = DW
) (
    input  logic          clk,
    input  logic          rst,
    input  cpu_dec_t      dec,
    input  logic [W-1:0]  wdata,
    input  logic          line_evt,
    input  logic [CW-1:0] line_next,
    output logic          pending,
    output logic          enable
);

    logic [CW-1:0] target_q;
    logic          pend_q;
    logic          en_q;
    logic          set_evt;

    assign set_evt = line_evt && (line_next == target_q);
    assign pending = pend_q;
    assign enable  = en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            target_q <= '0;
            pend_q   <= 1'b0;
            en_q     <= 1'b0;
        end else begin
            if (dec.wr_target) target_q <= wdata[CW-1:0];
            if (dec.wr_status) en_q     <= wdata[EN_BIT];
            if (set_evt)            pend_q <= 1'b1;
            else if (dec.rd_status) pend_q <= 1'b0;
        end
    end

    // R5
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> pend_q);

    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.rd_status && !set_evt) |=> !pend_q);

endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit
    import scanirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_stb,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rnw,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    input  logic              ppu_stb,
    input  logic [PPU_AW-1:0] ppu_addr,
    input  logic              ppu_rnw,
    output logic              irq_n
);

    cpu_dec_t          dec;
    logic              ppu_rd;
    logic              line_hit;
    logic              starve_now;
    logic              end_frame;
    logic              in_frame;
    logic [LINE_W-1:0] line;
    logic              line_evt;
    logic [LINE_W-1:0] line_next;
    logic              pending;
    logic              enable;

    assign dec       = decode_cpu(cpu_stb, cpu_rnw, cpu_addr);
    assign ppu_rd    = ppu_stb && ppu_rnw;
    assign end_frame = starve_now || dec.rd_vector;

    fetch_run_detector #(.AW(PPU_AW), .QUAL_BIT(A13_BIT)) u_run (
        .clk      (clk),
        .rst      (rst),
        .rd_stb   (ppu_rd),
        .addr     (ppu_addr),
        .line_hit (line_hit)
    );

    starve_monitor #(.LIMIT(STARVE_CYC)) u_starve (
        .clk        (clk),
        .rst        (rst),
        .cpu_stb    (cpu_stb),
        .ppu_rd     (ppu_rd),
        .starve_now (starve_now)
    );

    frame_tracker #(.CW(LINE_W)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .hit       (line_hit),
        .end_frame (end_frame),
        .in_frame  (in_frame),
        .line      (line),
        .line_evt  (line_evt),
        .line_next (line_next)
    );

    irq_regs #(.CW(LINE_W), .W(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .wdata     (cpu_wdata),
        .line_evt  (line_evt),
        .line_next (line_next),
        .pending   (pending),
        .enable    (enable)
    );

    always_comb begin
        cpu_rdata = '0;
        if (dec.rd_status) begin
            cpu_rdata[PEND_BIT]  = pending;
            cpu_rdata[INFRM_BIT] = in_frame && !end_frame;
        end
    end

    assign irq_n = ~(pending & enable);

    // R7
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (enable && pending));

    // R10
    ppu_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (ppu_stb && !ppu_rnw && !cpu_stb) |=> $stable(line) && $stable(in_frame));

endmodule

// File: tb/scanline_irq_unit_test.sv
module scanline_irq_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_stb = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rnw = 1'b1;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        ppu_stb = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic        ppu_rnw = 1'b1;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expected state computed from the requirements
    logic [13:0] m_last;
    logic        m_hv;
    int          m_run;
    logic        m_inf;
    logic [7:0]  m_line;
    logic [7:0]  m_tgt;
    logic        m_pend;
    logic        m_en;
    int          m_idle;

    always #(CLK_PERIOD/2) clk = ~clk;

    scanline_irq_unit uut (
        .clk(clk), .rst(rst),
        .cpu_stb(cpu_stb), .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ppu_stb(ppu_stb), .ppu_addr(ppu_addr), .ppu_rnw(ppu_rnw),
        .irq_n(irq_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_last = '0; m_hv = 0; m_run = 0; m_inf = 0; m_line = '0;
        m_tgt = '0; m_pend = 0; m_en = 0; m_idle = 0;
    endtask

    task automatic ppu_read(input logic [13:0] a);
        bit same;
        bit det;
        @(negedge clk);
        ppu_stb = 1'b1; ppu_rnw = 1'b1; ppu_addr = a;
        @(posedge clk);
        #1 ppu_stb = 1'b0;
        same = m_hv && (a == m_last);
        det  = same && (m_run >= 2) && a[13];
        m_run = same ? ((m_run < 3) ? m_run + 1 : 3) : 1;
        m_last = a; m_hv = 1; m_idle = 0;
        if (det) begin
            if (!m_inf) begin m_inf = 1; m_line = 0; end
            else m_line = m_line + 1;
            if (m_line == m_tgt) m_pend = 1;
        end
    endtask

    task automatic ppu_write(input logic [13:0] a);
        @(negedge clk);
        ppu_stb = 1'b1; ppu_rnw = 1'b0; ppu_addr = a;
        @(posedge clk);
        #1 ppu_stb = 1'b0; ppu_rnw = 1'b1;
    endtask

    task automatic cpu_cycle(input logic [15:0] a, input bit rd, input logic [7:0] d,
                             output logic [7:0] q, output logic [7:0] exp);
        bit stv;
        @(negedge clk);
        cpu_stb = 1'b1; cpu_addr = a; cpu_rnw = rd; cpu_wdata = d;
        #1 q = cpu_rdata;
        stv = (m_idle == 2);
        exp = (rd && a == 16'h5204) ? {m_pend, m_inf && !stv, 6'b0} : 8'h00;
        @(posedge clk);
        #1 cpu_stb = 1'b0; cpu_rnw = 1'b1;
        if (stv || (rd && (a == 16'hFFFA || a == 16'hFFFB))) begin m_inf = 0; m_line = 0; end
        if (m_idle < 2) m_idle++;
        if (rd && a == 16'h5204) m_pend = 0;
        if (!rd && a == 16'h5203) m_tgt = d;
        if (!rd && a == 16'h5204) m_en = d[7];
    endtask

    task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
        logic [7:0] q, e;
        cpu_cycle(a, 1'b0, d, q, e);
    endtask

    task automatic status(input string req);
        logic [7:0] q, e;
        check({req, " irq_n"}, int'(irq_n), int'(!(m_pend && m_en)));
        cpu_cycle(16'h5204, 1'b1, 8'h00, q, e);
        check({req, " status"}, int'(q), int'(e));
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] q, e;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R11 reset state
        @(negedge clk);
        check("R11 irq_n", int'(irq_n), 1);
        check("R11 rdata idle", int'(cpu_rdata), 0);
        status("R11");

        // R6 other address reads 0
        cpu_cycle(16'h5203, 1'b1, 8'h00, q, e);
        check("R6 other addr", int'(q), 0);

        // sweep: run length x target x bit 13 (R1 R2 R3 R4 R5 R7)
        for (int a13 = 0; a13 < 2; a13++) begin
            for (int len = 2; len <= 4; len++) begin
                for (int tg = 0; tg < 5; tg++) begin
                    cpu_cycle(16'hFFFA, 1'b1, 8'h00, q, e);
                    cpu_wr(16'h5203, 8'(tg));
                    cpu_wr(16'h5204, 8'h80);
                    status("R6 ack");
                    for (int ln = 0; ln < 7; ln++) begin
                        for (int k = 0; k < len; k++)
                            ppu_read(14'(a13 << 13) | 14'h0123);
                        ppu_read(14'h0040);
                        status("R1 R2 R3 R4 R5 R7 sweep");
                    end
                end
            end
        end

        // single-bit difference in the first fetch of every run (R2)
        for (int b = 0; b < 14; b++) begin
            cpu_cycle(16'hFFFB, 1'b1, 8'h00, q, e);
            cpu_wr(16'h5203, 8'd1);
            for (int ln = 0; ln < 4; ln++) begin
                ppu_read(14'h2000 ^ 14'(1 << b));
                ppu_read(14'h2000);
                ppu_read(14'h2000);
                ppu_read(14'h0000);
                status("R2 bit flip");
            end
        end

        // R9: third starved cycle clears in-frame, same-cycle read sees 0
        cpu_wr(16'h5204, 8'h00);
        repeat (3) ppu_read(14'h2ABC);
        cpu_cycle(16'h5204, 1'b1, 8'h00, q, e);
        check("R9 first idle", int'(q[6]), 1);
        cpu_cycle(16'h5204, 1'b1, 8'h00, q, e);
        check("R9 second idle", int'(q[6]), 1);
        cpu_cycle(16'h5204, 1'b1, 8'h00, q, e);
        check("R9 third idle", int'(q[6]), 0);
        check("R9 model", int'(q), int'(e));

        // R10: picture writes do not rearm the starve count
        repeat (3) ppu_read(14'h2ABC);
        cpu_cycle(16'h0000, 1'b1, 8'h00, q, e);
        ppu_write(14'h2ABC);
        cpu_cycle(16'h0000, 1'b1, 8'h00, q, e);
        ppu_write(14'h2ABC);
        cpu_cycle(16'h5204, 1'b1, 8'h00, q, e);
        check("R10 write ignored", int'(q[6]), 0);

        // R10: a write inside a run does not break the match
        ppu_read(14'h2111);
        ppu_read(14'h2111);
        ppu_write(14'h0000);
        ppu_read(14'h2111);
        status("R10 run");

        // R8: vector writes and 0x00 to 0x2001 keep the frame
        ppu_read(14'h2111);
        cpu_wr(16'hFFFA, 8'h00);
        ppu_read(14'h2111);
        cpu_wr(16'hFFFB, 8'h00);
        ppu_read(14'h2111);
        cpu_wr(16'h2001, 8'h00);
        ppu_read(14'h2111);
        cpu_cycle(16'h5204, 1'b1, 8'h00, q, e);
        check("R8 writes ignored", int'(q[6]), 1);
        check("R8 model", int'(q), int'(e));
        ppu_read(14'h2111);
        cpu_cycle(16'hFFFB, 1'b1, 8'h00, q, e);
        ppu_read(14'h0000);
        cpu_cycle(16'h5204, 1'b1, 8'h00, q, e);
        check("R8 vector read", int'(q[6]), 0);

        // R7: enable off masks, on exposes pending
        cpu_wr(16'h5203, 8'd0);
        cpu_wr(16'h5204, 8'h00);
        repeat (3) ppu_read(14'h3000);
        ppu_read(14'h0000);
        check("R7 masked", int'(irq_n), 1);
        cpu_wr(16'h5204, 8'h80);
        ppu_read(14'h0000);
        check("R7 asserted", int'(irq_n), 0);
        status("R7 ack");
        ppu_read(14'h0000);
        check("R7 released", int'(irq_n), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule